// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver (Inverted Line Polarity)

This block turns an asynchronous serial line into parallel bytes. The line rests low. A frame begins with a high start bit. Eight data bits follow, least significant first, and the frame closes with a low stop bit. The block is clocked at sixteen times the bit rate. A two-flop synchronizer cleans up the line first. A down-counting bit-time divider is then preloaded so that its first terminal count falls in the middle of the start bit, and from that point it ticks once per bit period. A bit counter tracks how many data bits remain. A right-shifting deserializer collects the samples. A six-state controller sequences the whole receive.

When the stop bit is low, the received byte is copied into an output holding register and a ready flag is raised for exactly one bit period. When the stop bit is high, the frame is dropped. The controller then waits until the line falls low before it looks for another start bit. Software or a downstream block reads the byte while ready is high. The byte stays on the output until the next good frame replaces it.

Top module: `serial_rx_inv`

## Requirements
- R1: A frame is one high start bit, then 8 data bits with the least significant bit first, then one low stop bit, each bit lasting 16 clocks. After a good frame, data_o bit 0 holds the first data bit received and bit 7 holds the last.
- R2: Counting the first rising edge at which line_i is high as edge 1, ready_o first reads high after rising edge 154 for a frame with ideal 16-clock bit cells.
- R3: ready_o stays high for exactly 16 consecutive clocks per good frame. It then returns low.
- R4: A high pulse on line_i that lasts 7 clocks or less is rejected and produces no ready_o. A pulse of exactly 8 clocks followed by a low line is accepted as a start bit, which yields ready_o with data_o = 8'h00.
- R5: A frame whose stop bit is high never raises ready_o and leaves data_o unchanged.
- R6: After a high stop bit, the receiver waits for the line to go low. A line that stays high after that stop bit starts no new frame. The next frame that begins after the line is low is received normally.
- R7: data_o changes only in the clock cycle in which ready_o rises. At every other time it holds its value.
- R8: While rst_i is high at a rising edge, the receiver returns to idle, ready_o reads 0 and data_o reads 8'h00. A frame that is cut off by reset produces no ready_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive clock, 16 times the bit rate |
| rst_i | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Asynchronous serial line, idle low |
| data_o | output | 8 | Last correctly received byte |
| ready_o | output | 1 | High for one bit period after a good frame |

## Verification
A divider preload or synchronizer depth that is off by one moves the rising edge of ready_o away from cycle 154. This is visible on the very first frame. It also shifts the shortest accepted start pulse away from eight clocks. A bit counter or controller that leaves its sequence shows up as a wrong byte, a ready pulse whose width is not 16, or a data_o that changes outside the ready edge. Each of these appears within one frame time, about 170 clocks. A missing recovery state stays hidden until the line is held high after a bad stop bit. The receiver then assembles a bogus frame and raises ready_o roughly one frame later.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_CAPTURE,
        ST_READY,
        ST_RECOVER
    } rx_state_e;
endpackage

// File: rtl/rxi_sync.sv
module rxi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= sync_d;
    end

    assign dout_o = sync_q[STAGES-1];
endmodule

// File: rtl/rxi_down_counter.sv
module rxi_down_counter #(
    parameter int WIDTH    = 4,
    parameter int WRAP_VAL = 15,
    parameter bit CYCLIC   = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    localparam logic [WIDTH-1:0] WRAP = WIDTH'(WRAP_VAL);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i) begin
            if (cnt_q != '0)  cnt_d = cnt_q - WIDTH'(1);
            else if (CYCLIC)  cnt_d = WRAP;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    generate
        if (!CYCLIC) begin : g_oneshot_chk
            // R1
            no_underflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                (dec_i && !load_i) |-> (cnt_q != '0));
        end
    endgenerate
endmodule

// File: rtl/rxi_shifter.sv
module rxi_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             shift_i,
    input  logic             ser_i,
    input  logic             latch_i,
    output logic [WIDTH-1:0] par_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
        logic [WIDTH-1:0] hold;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (shift_i) shf_d.sr   = {ser_i, shf_q.sr[WIDTH-1:1]};
        if (latch_i) shf_d.hold = shf_q.sr;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) shf_q <= '0;
        else       shf_q <= shf_d;
    end

    assign par_o = shf_q.hold;
endmodule

// File: rtl/rxi_ctrl.sv
module rxi_ctrl
    import rxi_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    input  logic tc_i,
    input  logic bits_done_i,
    output logic div_load_o,
    output logic bit_load_o,
    output logic bit_dec_o,
    output logic shift_o,
    output logic latch_o,
    output logic ready_o
);
    typedef struct packed {
        rx_state_e st;
        logic      ready;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        div_load_o = 1'b0;
        bit_load_o = 1'b0;
        bit_dec_o  = 1'b0;
        shift_o    = 1'b0;
        latch_o    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                div_load_o = 1'b1;
                bit_load_o = 1'b1;
                if (line_i) ctl_d.st = ST_START;
            end
            ST_START: begin
                if (!line_i)   ctl_d.st = ST_IDLE;
                else if (tc_i) ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (tc_i) begin
                    if (!bits_done_i) begin
                        ctl_d.st = ST_CAPTURE;
                    end else if (!line_i) begin
                        ctl_d.st = ST_READY;
                        latch_o  = 1'b1;
                    end else begin
                        ctl_d.st = ST_RECOVER;
                    end
                end
            end
            ST_CAPTURE: begin
                shift_o   = 1'b1;
                bit_dec_o = 1'b1;
                ctl_d.st  = ST_WAIT;
            end
            ST_READY: begin
                if (tc_i) ctl_d.st = ST_IDLE;
            end
            ST_RECOVER: begin
                if (!line_i) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        ctl_d.ready = (ctl_d.st == ST_READY);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ctl_q <= '{st: ST_IDLE, ready: 1'b0};
        else       ctl_q <= ctl_d;
    end

    assign ready_o = ctl_q.ready;

    // R2
    capture_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_q.st == ST_CAPTURE) |-> $past(tc_i));

    // R3
    ready_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ctl_q.ready) |-> $past(tc_i));

    // R5
    ready_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ctl_q.ready) |-> ($past(ctl_q.st) == ST_WAIT && $past(bits_done_i) && !$past(line_i)));
endmodule

// File: rtl/serial_rx_inv.sv
module serial_rx_inv #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 line_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 ready_o
);
    localparam int DIV_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = $clog2(DATA_BITS + 1);
    // Synchronizer stages plus the detect cycle are absorbed by the preload.
    localparam logic [DIV_W-1:0] MID_LOAD  = DIV_W'(OVERSAMPLE / 2 - SYNC_STAGES);
    localparam logic [BIT_W-1:0] BITS_LOAD = BIT_W'(DATA_BITS);

    logic line_s;
    logic tc, bits_done;
    logic div_load, bit_load, bit_dec, shift, latch;

    rxi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .din_i  (line_i),
        .dout_o (line_s)
    );

    rxi_down_counter #(.WIDTH(DIV_W), .WRAP_VAL(OVERSAMPLE - 1), .CYCLIC(1'b1)) u_bit_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (div_load),
        .load_val_i (MID_LOAD),
        .dec_i      (1'b1),
        .zero_o     (tc)
    );

    rxi_down_counter #(.WIDTH(BIT_W), .WRAP_VAL(0), .CYCLIC(1'b0)) u_bit_count (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (bit_load),
        .load_val_i (BITS_LOAD),
        .dec_i      (bit_dec),
        .zero_o     (bits_done)
    );

    rxi_ctrl u_ctrl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .line_i      (line_s),
        .tc_i        (tc),
        .bits_done_i (bits_done),
        .div_load_o  (div_load),
        .bit_load_o  (bit_load),
        .bit_dec_o   (bit_dec),
        .shift_o     (shift),
        .latch_o     (latch),
        .ready_o     (ready_o)
    );

    rxi_shifter #(.WIDTH(DATA_BITS)) u_shifter (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (shift),
        .ser_i   (line_s),
        .latch_i (latch),
        .par_o   (data_o)
    );

    // R7
    data_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$rose(ready_o) |-> $stable(data_o));
endmodule

// File: tb/test_serial_rx_inv.sv
`timescale 1ns/1ps
module test_serial_rx_inv;
    localparam int W       = 8;
    localparam int WINDOW  = 420;
    localparam int RISE_AT = 154;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         line = 1'b0;
    logic [W-1:0] data;
    logic         ready;
    int           checks = 0;
    int           fails = 0;
    bit           finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_rx_inv i_serial_rx_inv (
        .clk_i   (clk),
        .rst_i   (rst),
        .line_i  (line),
        .data_o  (data),
        .ready_o (ready)
    );

    // {data byte, stop bit level, ready expected}
    localparam logic [9:0] VEC [7] = '{
        {8'hA5, 1'b0, 1'b1},
        {8'h00, 1'b0, 1'b1},
        {8'hFF, 1'b0, 1'b1},
        {8'h01, 1'b0, 1'b1},
        {8'h80, 1'b0, 1'b1},
        {8'h3C, 1'b1, 1'b0},
        {8'h5A, 1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic bit_at(input int p, input logic [W-1:0] d,
                                    input logic stop, input int tail_hi);
        int idx = (p - 1) / 16;
        if (idx == 0)           return 1'b1;
        if (idx <= 8)           return d[idx-1];
        if (idx == 9)           return stop;
        if (p - 160 <= tail_hi) return 1'b1;
        return 1'b0;
    endfunction

    // Drive a frame on the line and watch the outputs for WINDOW cycles.
    task automatic run_frame(input logic [W-1:0] d, input logic stop, input int tail_hi,
                             output int first, output int cnt, output int chg);
        logic [W-1:0] prev_d = data;
        logic         prev_r = ready;
        first = -1; cnt = 0; chg = 0;
        for (int p = 1; p <= WINDOW; p++) begin
            @(negedge clk);
            if (ready) begin
                if (first < 0) first = p - 1;
                cnt++;
            end
            if (data != prev_d && !(ready && !prev_r)) chg++;
            prev_d = data;
            prev_r = ready;
            line = bit_at(p, d, stop, tail_hi);
        end
    endtask

    task automatic pulse_watch(input int len, output int first, output int cnt);
        first = -1; cnt = 0;
        for (int p = 1; p <= WINDOW; p++) begin
            @(negedge clk);
            if (ready) begin
                if (first < 0) first = p - 1;
                cnt++;
            end
            line = (p <= len);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        int           first, cnt, chg;
        logic [W-1:0] last = '0;

        // R8: reset state
        repeat (4) @(negedge clk);
        check(ready == 1'b0, "R8", "ready in reset", ready, 0);
        check(data == '0, "R8", "data in reset", data, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);

        for (int i = 0; i < 7; i++) begin
            logic [W-1:0] d    = VEC[i][9:2];
            logic         stop = VEC[i][1];
            logic         good = VEC[i][0];
            run_frame(d, stop, 0, first, cnt, chg);
            check(chg == 0, "R7", "data changed off ready edge", chg, 0);
            if (good) begin
                check(first == RISE_AT, "R2", "ready rise cycle", first, RISE_AT);
                check(cnt == 16, "R3", "ready width", cnt, 16);
                check(data == d, "R1", "received byte", data, d);
                last = d;
            end else begin
                check(cnt == 0, "R5", "ready after high stop", cnt, 0);
                check(data == last, "R5", "byte kept after high stop", data, last);
            end
        end

        // R4: 7-clock pulse rejected
        pulse_watch(7, first, cnt);
        check(cnt == 0, "R4", "ready after 7-clock pulse", cnt, 0);
        check(data == last, "R4", "byte after 7-clock pulse", data, last);
        // R4: 8-clock pulse accepted as start of an all-zero frame
        pulse_watch(8, first, cnt);
        check(first == RISE_AT, "R4", "ready rise after 8-clock pulse", first, RISE_AT);
        check(cnt == 16, "R4", "ready width after 8-clock pulse", cnt, 16);
        check(data == 8'h00, "R4", "byte after 8-clock pulse", data, 0);
        last = 8'h00;

        // R6: high stop, line held high, then low: no bogus frame
        run_frame(8'hC3, 1'b1, 60, first, cnt, chg);
        check(cnt == 0, "R6", "ready during recovery", cnt, 0);
        check(data == last, "R6", "byte during recovery", data, last);
        run_frame(8'h96, 1'b0, 0, first, cnt, chg);
        check(cnt == 16, "R6", "ready after recovery", cnt, 16);
        check(data == 8'h96, "R6", "byte after recovery", data, 8'h96);

        // R8: reset in the middle of a frame
        for (int p = 1; p <= 80; p++) begin
            @(negedge clk);
            line = bit_at(p, 8'hE7, 1'b0, 0);
        end
        @(negedge clk);
        rst  = 1'b1;
        line = 1'b0;
        repeat (2) @(negedge clk);
        check(ready == 1'b0, "R8", "ready after mid-frame reset", ready, 0);
        check(data == '0, "R8", "byte after mid-frame reset", data, 0);
        rst = 1'b0;
        pulse_watch(0, first, cnt);
        check(cnt == 0, "R8", "ready from aborted frame", cnt, 0);
        run_frame(8'h4D, 1'b0, 0, first, cnt, chg);
        check(first == RISE_AT, "R2", "ready rise after reset", first, RISE_AT);
        check(data == 8'h4D, "R1", "byte after reset", data, 8'h4D);

        finish_run();
    end
endmodule